// File: doc/BRIEF.md
# Inclusive Two-Level Cache Tag Controller

This block keeps the tag and valid state for two direct-mapped cache levels that sit one behind the other. The near level (L1) uses small lines. The far level (L2) uses lines four times as large, so each L2 line spans four consecutive L1 lines. A processor lookup returns whether it hit in either level. A miss in both levels asks memory for the whole L2 line and then installs tags in both levels. An external coherence port can remove lines from L2.

Because the line sizes differ, installing an L2 line can silently strand L1 lines that belonged to the displaced L2 line. The controller prevents this. Whenever an L2 entry is displaced or invalidated, it walks the four L1 positions that the old L2 line covered, one per cycle. It clears each one whose tag shows it came from that line. This keeps every valid L1 line backed by a valid L2 line. Only tags and valid bits are held: no data, no dirty state, one way per set.

The controller is one state machine with six named states:
- `CIT_IDLE` accepts work.
- `CIT_LOOK` compares tags.
- `CIT_PROBE` steps through the four covered L1 positions.
- `CIT_FETCH` waits for the memory line.
- `CIT_RESP` raises the one-cycle completion.
- `CIT_INVCHK` tests an external invalidate against L2.

The transitions are:
- IDLE→INVCHK when an invalidate is held.
- IDLE→LOOK on an accepted request.
- LOOK→RESP on an L1 hit, or on an L1 miss with an L2 hit.
- LOOK→PROBE on a double miss whose L2 victim is valid.
- LOOK→FETCH on a double miss with an empty victim.
- PROBE→PROBE while positions remain.
- PROBE→FETCH after the last position of an eviction.
- PROBE→IDLE after the last position of an invalidate.
- FETCH→RESP on the memory acknowledge.
- RESP→IDLE.
- INVCHK→PROBE on an L2 hit.
- INVCHK→IDLE on an L2 miss.

Top module: `incl_tag_ctrl`

## Requirements
- R1: Reset clears every valid bit in both levels. After reset `req_ready`=1, `resp_done`=0 and `mem_req`=0, and the first access to any address misses in both levels without any probe cycles (completion 3 cycles after acceptance).
- R2: With default parameters the 16-bit address splits as follows:
  - L1 uses offset [3:0], index [7:4] and tag [15:8].
  - L2 uses offset [5:0], index [10:6] and tag [15:11].
  - `mem_line_addr` is the request address with bits [5:0] forced to zero.
- R3: A lookup that hits in L1 completes with `resp_l1_hit`=1 and `resp_l2_hit`=1, 2 cycles after acceptance, with no memory request.
- R4: A lookup that misses L1 but hits L2 installs only the L1 line. It completes with `resp_l1_hit`=0 and `resp_l2_hit`=1, 2 cycles after acceptance, with no memory request.
- R5: A lookup that misses both levels issues exactly one memory request for the enclosing L2 line. On `mem_ack` it installs that L2 line and the requested L1 line.
- R6: If the L2 entry to be replaced is valid, four probe cycles run before the memory request. Probe k (k=0..3) clears the L1 line at the index of old-line-base + k·L1-line-size, but only if its tag matches. Another line at that index with a different tag is kept. Such a miss completes 7 cycles after acceptance when memory answers at once.
- R7: `req_ready` stays low from acceptance until completion, and also while a held invalidate is being tested and probed.
- R8: An external invalidate that hits in L2 clears the L2 entry and probes all four covered L1 positions. `req_ready` returns 7 cycles after the invalidate is accepted.
- R9: An external invalidate that misses in L2 changes nothing. `req_ready` returns 3 cycles after acceptance.
- R10: An invalidate offered while a lookup is in progress is accepted into a one-entry hold when `inv_ready`=1. It leaves the running lookup's result untouched and is applied after that lookup completes.
- R11: Inclusion: any lookup that finds its line valid in L1 also finds the containing L2 line valid.
- R12: `resp_done` is a single-cycle pulse. `mem_req` stays high with a stable `mem_line_addr` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor lookup offered |
| req_addr | input | ADDR_W | Lookup byte address |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| resp_done | output | 1 | One-cycle lookup completion |
| resp_l1_hit | output | 1 | Completed lookup hit in L1 |
| resp_l2_hit | output | 1 | Completed lookup hit in L2 |
| mem_req | output | 1 | Request for one L2 line from memory |
| mem_line_addr | output | ADDR_W | L2-line-aligned address of the request |
| mem_ack | input | 1 | Memory has delivered the requested line |
| inv_valid | input | 1 | External invalidate offered |
| inv_addr | input | ADDR_W | Address inside the line to invalidate |
| inv_ready | output | 1 | Invalidate hold register is free |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high. They also assume that an invalidate is offered only while `inv_ready` is high, so that no offered invalidate is lost. The stimulus answers each memory request in the cycle after it appears and never repeats an acknowledge. It raises `inv_valid` for exactly one accepting cycle, either when the controller is idle or during a lookup while the hold is empty. Lookups are always offered and held until `req_ready` is seen. Every completion is therefore observed at a known cycle count.

// File: rtl/cit_pkg.sv
package cit_pkg;

    // Controller states; the brief names each state and transition.
    typedef enum logic [2:0] {
        CIT_IDLE,
        CIT_LOOK,
        CIT_PROBE,
        CIT_FETCH,
        CIT_RESP,
        CIT_INVCHK
    } cit_state_e;

endpackage

// File: rtl/cit_tag_array.sv
// Direct-mapped tag store: one combinational read port, one write port.
module cit_tag_array #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [DEPTH];

    // Valid bits are reset; tag contents only matter once valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_valid) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/cit_addr_fields.sv
// Splits a byte address into the index and tag of both levels.
module cit_addr_fields #(
    parameter int ADDR_W   = 16,
    parameter int L1_OFF_W = 4,
    parameter int L1_IDX_W = 4,
    parameter int RATIO_W  = 2,
    parameter int L2_IDX_W = 5
) (
    input  logic [ADDR_W-1:0]                           addr,
    output logic [L1_IDX_W-1:0]                         l1_idx,
    output logic [ADDR_W-L1_OFF_W-L1_IDX_W-1:0]         l1_tag,
    output logic [L2_IDX_W-1:0]                         l2_idx,
    output logic [ADDR_W-L1_OFF_W-RATIO_W-L2_IDX_W-1:0] l2_tag,
    output logic [ADDR_W-1:0]                           line_base
);
    localparam int L2_OFF_W = L1_OFF_W + RATIO_W;
    localparam int L1_TOP   = L1_OFF_W + L1_IDX_W;
    localparam int L2_TOP   = L2_OFF_W + L2_IDX_W;

    assign l1_idx    = addr[L1_OFF_W +: L1_IDX_W];
    assign l1_tag    = addr[ADDR_W-1:L1_TOP];
    assign l2_idx    = addr[L2_OFF_W +: L2_IDX_W];
    assign l2_tag    = addr[ADDR_W-1:L2_TOP];
    assign line_base = {addr[ADDR_W-1:L2_OFF_W], {L2_OFF_W{1'b0}}};

endmodule

// File: rtl/cit_probe_addr.sv
// Rebuilds the L1 index/tag of sub-block `sub` inside an L2 line.
module cit_probe_addr #(
    parameter int ADDR_W   = 16,
    parameter int L1_OFF_W = 4,
    parameter int L1_IDX_W = 4,
    parameter int RATIO_W  = 2,
    parameter int L2_IDX_W = 5
) (
    input  logic [ADDR_W-L1_OFF_W-RATIO_W-L2_IDX_W-1:0] l2_tag,
    input  logic [L2_IDX_W-1:0]                         l2_idx,
    input  logic [RATIO_W-1:0]                          sub,
    output logic [L1_IDX_W-1:0]                         l1_idx,
    output logic [ADDR_W-L1_OFF_W-L1_IDX_W-1:0]         l1_tag
);
    localparam int LINE_W = ADDR_W - L1_OFF_W;

    logic [LINE_W-1:0] l1_line;

    assign l1_line = {l2_tag, l2_idx, sub};
    assign l1_idx  = l1_line[L1_IDX_W-1:0];
    assign l1_tag  = l1_line[LINE_W-1:L1_IDX_W];

endmodule

// File: rtl/incl_tag_ctrl.sv
module incl_tag_ctrl
    import cit_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int L1_OFF_W = 4,
    parameter int L1_IDX_W = 4,
    parameter int RATIO_W  = 2,
    parameter int L2_IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_done,
    output logic              resp_l1_hit,
    output logic              resp_l2_hit,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_line_addr,
    input  logic              mem_ack,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_addr,
    output logic              inv_ready
);
    localparam int L1_TAG_W = ADDR_W - L1_OFF_W - L1_IDX_W;
    localparam int L2_TAG_W = ADDR_W - L1_OFF_W - RATIO_W - L2_IDX_W;
    localparam logic [RATIO_W-1:0] SUB_LAST = {RATIO_W{1'b1}};

    cit_state_e state_q, state_d;

    logic [ADDR_W-1:0]   op_addr_q, op_addr_d;
    logic [RATIO_W-1:0]  sub_q, sub_d;
    logic [L2_TAG_W-1:0] vic_tag_q, vic_tag_d;
    logic                inv_mode_q, inv_mode_d;
    logic                hit1_q, hit1_d, hit2_q, hit2_d;
    logic                pend_q, pend_d;
    logic [ADDR_W-1:0]   pend_addr_q, pend_addr_d;

    // Field split of the operation address.
    logic [L1_IDX_W-1:0] op_l1_idx;
    logic [L1_TAG_W-1:0] op_l1_tag;
    logic [L2_IDX_W-1:0] op_l2_idx;
    logic [L2_TAG_W-1:0] op_l2_tag;
    logic [ADDR_W-1:0]   op_line;

    cit_addr_fields #(
        .ADDR_W(ADDR_W), .L1_OFF_W(L1_OFF_W), .L1_IDX_W(L1_IDX_W),
        .RATIO_W(RATIO_W), .L2_IDX_W(L2_IDX_W)
    ) u_fields (
        .addr(op_addr_q), .l1_idx(op_l1_idx), .l1_tag(op_l1_tag),
        .l2_idx(op_l2_idx), .l2_tag(op_l2_tag), .line_base(op_line)
    );

    // Sub-block currently probed inside the displaced L2 line.
    logic [L1_IDX_W-1:0] pr_l1_idx;
    logic [L1_TAG_W-1:0] pr_l1_tag;

    cit_probe_addr #(
        .ADDR_W(ADDR_W), .L1_OFF_W(L1_OFF_W), .L1_IDX_W(L1_IDX_W),
        .RATIO_W(RATIO_W), .L2_IDX_W(L2_IDX_W)
    ) u_probe (
        .l2_tag(vic_tag_q), .l2_idx(op_l2_idx), .sub(sub_q),
        .l1_idx(pr_l1_idx), .l1_tag(pr_l1_tag)
    );

    // Tag stores.
    logic                l1_rd_idx_sel;
    logic [L1_IDX_W-1:0] l1_rd_idx;
    logic                l1_rd_valid;
    logic [L1_TAG_W-1:0] l1_rd_tag;
    logic                l1_we, l1_wv;
    logic [L1_IDX_W-1:0] l1_widx;
    logic [L1_TAG_W-1:0] l1_wtag;

    logic                l2_rd_valid;
    logic [L2_TAG_W-1:0] l2_rd_tag;
    logic                l2_we, l2_wv;

    assign l1_rd_idx_sel = (state_q == CIT_PROBE);
    assign l1_rd_idx     = l1_rd_idx_sel ? pr_l1_idx : op_l1_idx;

    cit_tag_array #(.IDX_W(L1_IDX_W), .TAG_W(L1_TAG_W)) u_l1 (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(l1_rd_idx), .rd_valid(l1_rd_valid), .rd_tag(l1_rd_tag),
        .wr_en(l1_we), .wr_idx(l1_widx), .wr_valid(l1_wv), .wr_tag(l1_wtag)
    );

    cit_tag_array #(.IDX_W(L2_IDX_W), .TAG_W(L2_TAG_W)) u_l2 (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(op_l2_idx), .rd_valid(l2_rd_valid), .rd_tag(l2_rd_tag),
        .wr_en(l2_we), .wr_idx(op_l2_idx), .wr_valid(l2_wv), .wr_tag(op_l2_tag)
    );

    logic l1_hit, l2_hit, pr_match;
    assign l1_hit   = l1_rd_valid && (l1_rd_tag == op_l1_tag);
    assign l2_hit   = l2_rd_valid && (l2_rd_tag == op_l2_tag);
    assign pr_match = l1_rd_valid && (l1_rd_tag == pr_l1_tag);

    // Next state, array writes and held context.
    always_comb begin
        state_d     = state_q;
        op_addr_d   = op_addr_q;
        sub_d       = sub_q;
        vic_tag_d   = vic_tag_q;
        inv_mode_d  = inv_mode_q;
        hit1_d      = hit1_q;
        hit2_d      = hit2_q;
        pend_d      = pend_q;
        pend_addr_d = pend_addr_q;
        l1_we       = 1'b0;
        l1_wv       = 1'b0;
        l1_widx     = op_l1_idx;
        l1_wtag     = op_l1_tag;
        l2_we       = 1'b0;
        l2_wv       = 1'b0;

        if (inv_valid && !pend_q) begin
            pend_d      = 1'b1;
            pend_addr_d = inv_addr;
        end

        unique case (state_q)
            CIT_IDLE: begin
                if (pend_q) begin
                    op_addr_d = pend_addr_q;
                    pend_d    = 1'b0;
                    state_d   = CIT_INVCHK;
                end else if (req_valid) begin
                    op_addr_d = req_addr;
                    state_d   = CIT_LOOK;
                end
            end
            CIT_LOOK: begin
                hit1_d = l1_hit;
                hit2_d = l2_hit;
                if (l1_hit) begin
                    state_d = CIT_RESP;
                end else if (l2_hit) begin
                    l1_we   = 1'b1;
                    l1_wv   = 1'b1;
                    state_d = CIT_RESP;
                end else if (l2_rd_valid) begin
                    vic_tag_d  = l2_rd_tag;
                    sub_d      = '0;
                    inv_mode_d = 1'b0;
                    state_d    = CIT_PROBE;
                end else begin
                    state_d = CIT_FETCH;
                end
            end
            CIT_PROBE: begin
                if (pr_match) begin
                    l1_we   = 1'b1;
                    l1_wv   = 1'b0;
                    l1_widx = pr_l1_idx;
                end
                sub_d = sub_q + 1'b1;
                if (sub_q == SUB_LAST) begin
                    state_d = inv_mode_q ? CIT_IDLE : CIT_FETCH;
                end
            end
            CIT_FETCH: begin
                if (mem_ack) begin
                    l2_we   = 1'b1;
                    l2_wv   = 1'b1;
                    l1_we   = 1'b1;
                    l1_wv   = 1'b1;
                    state_d = CIT_RESP;
                end
            end
            CIT_RESP: begin
                state_d = CIT_IDLE;
            end
            CIT_INVCHK: begin
                if (l2_hit) begin
                    l2_we      = 1'b1;
                    l2_wv      = 1'b0;
                    vic_tag_d  = op_l2_tag;
                    sub_d      = '0;
                    inv_mode_d = 1'b1;
                    state_d    = CIT_PROBE;
                end else begin
                    state_d = CIT_IDLE;
                end
            end
            default: state_d = CIT_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= CIT_IDLE;
            op_addr_q   <= '0;
            sub_q       <= '0;
            vic_tag_q   <= '0;
            inv_mode_q  <= 1'b0;
            hit1_q      <= 1'b0;
            hit2_q      <= 1'b0;
            pend_q      <= 1'b0;
            pend_addr_q <= '0;
        end else begin
            state_q     <= state_d;
            op_addr_q   <= op_addr_d;
            sub_q       <= sub_d;
            vic_tag_q   <= vic_tag_d;
            inv_mode_q  <= inv_mode_d;
            hit1_q      <= hit1_d;
            hit2_q      <= hit2_d;
            pend_q      <= pend_d;
            pend_addr_q <= pend_addr_d;
        end
    end

    // Outputs.
    always_comb begin
        req_ready     = (state_q == CIT_IDLE) && !pend_q;
        resp_done     = (state_q == CIT_RESP);
        resp_l1_hit   = (state_q == CIT_RESP) && hit1_q;
        resp_l2_hit   = (state_q == CIT_RESP) && hit2_q;
        mem_req       = (state_q == CIT_FETCH);
        mem_line_addr = op_line;
        inv_ready     = !pend_q;
    end

    // Assertions next to the logic they guard.
    assert_incl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CIT_LOOK && l1_hit) |-> l2_hit)
        else $error("inclusion broken at lookup");

    assert_probe_blocks_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CIT_PROBE || state_q == CIT_INVCHK || state_q == CIT_FETCH) |-> !req_ready)
        else $error("request accepted while busy");

    assert_probe_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CIT_PROBE && sub_q != SUB_LAST) |=> (state_q == CIT_PROBE))
        else $error("probe walk cut short");

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done)
        else $error("completion longer than one cycle");

    assert_fetch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_line_addr)))
        else $error("memory request dropped before ack");

    assert_hold_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && state_q != CIT_IDLE) |=> (pend_q && $stable(pend_addr_q)))
        else $error("held invalidate lost");

endmodule

// File: tb/tb_incl_tag_ctrl.sv
module tb_incl_tag_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready, resp_done, resp_l1_hit, resp_l2_hit, mem_req, inv_ready;
    logic [15:0] mem_line_addr;
    logic        mem_ack = 1'b0;
    logic        inv_valid = 1'b0;
    logic [15:0] inv_addr = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    incl_tag_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_done(resp_done), .resp_l1_hit(resp_l1_hit), .resp_l2_hit(resp_l2_hit),
        .mem_req(mem_req), .mem_line_addr(mem_line_addr), .mem_ack(mem_ack),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ready(inv_ready)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One lookup; optionally offers an invalidate while it is running.
    task automatic access(input logic [15:0] a, input bit e1, input bit e2,
                          input int elat, input int emem, input string req,
                          input bit inv_mid = 1'b0, input logic [15:0] ia = '0);
        int n = 0, nmem = 0, rdy_hi = 0;
        logic [15:0] seen_line = '0;
        bit got1 = 0, got2 = 0, done = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        #1 req_valid = 1'b0;
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
            mem_ack = 1'b0;
            if (inv_mid && n == 2) begin
                inv_valid = 1'b1;
                inv_addr  = ia;
            end
            if (inv_mid && n == 3) inv_valid = 1'b0;
            if (req_ready) rdy_hi++;
            if (mem_req) begin
                nmem++;
                seen_line = mem_line_addr;
                mem_ack = 1'b1;
            end
            if (resp_done) begin
                got1 = resp_l1_hit;
                got2 = resp_l2_hit;
                done = 1;
            end
        end
        chk(got1 == e1, {req, " l1 hit flag"}, got1, e1);
        chk(got2 == e2, {req, " l2 hit flag"}, got2, e2);
        chk(n == elat, {req, " completion cycle"}, n, elat);
        chk(nmem == emem, {req, " memory requests"}, nmem, emem);
        chk(rdy_hi == 0, {req, " R7 ready during lookup"}, rdy_hi, 0);
        if (emem != 0)
            chk(seen_line == (a & 16'hFFC0), {req, " R2 line address"}, seen_line, a & 16'hFFC0);
    endtask

    // External invalidate from idle; measures the busy window.
    task automatic ext_inv(input logic [15:0] a, input int ebusy, input string req);
        int n = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        chk(inv_ready == 1'b1, {req, " inv_ready idle"}, inv_ready, 1);
        inv_valid = 1'b1;
        inv_addr  = a;
        @(posedge clk);
        #1 inv_valid = 1'b0;
        do begin
            @(negedge clk);
            n++;
        end while (!req_ready && n < 60);
        chk(n == ebusy, {req, " ready return cycle"}, n, ebusy);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk(resp_done == 1'b0, "R1 done after reset", resp_done, 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);
    endtask

    task automatic test_fill_and_hits();
        access(16'h0000, 0, 0, 3, 1, "R5 R1 cold miss");
        access(16'h0000, 1, 1, 2, 0, "R3 repeat hit");
        access(16'h0010, 0, 1, 2, 0, "R4 sibling in L2");
        access(16'h0010, 1, 1, 2, 0, "R3 sibling now in L1");
        access(16'h0020, 0, 1, 2, 0, "R4 third sibling");
    endtask

    task automatic test_eviction();
        access(16'h0800, 0, 0, 7, 1, "R6 conflict evicts line 0");
        access(16'h0020, 0, 0, 7, 1, "R6 R11 sibling cleared");
        access(16'h0010, 0, 1, 2, 0, "R6 second sibling cleared");
    endtask

    task automatic test_probe_tag_match();
        access(16'h0110, 0, 0, 3, 1, "R2 other L2 set");
        access(16'h0800, 0, 0, 7, 1, "R6 evict with foreign tag at index 1");
        access(16'h0110, 1, 1, 2, 0, "R6 foreign-tag line kept");
    endtask

    task automatic test_ext_inv();
        ext_inv(16'h0100, 7, "R8 invalidate hit");
        access(16'h0110, 0, 0, 3, 1, "R8 L1 and L2 cleared");
        ext_inv(16'h3000, 3, "R9 invalidate miss");
        access(16'h0800, 1, 1, 2, 0, "R9 nothing changed");
    endtask

    task automatic test_inv_during_miss();
        access(16'h4000, 0, 0, 7, 1, "R10 lookup with held invalidate", 1'b1, 16'h0100);
        access(16'h0110, 0, 0, 3, 1, "R10 held invalidate applied");
        access(16'h4000, 1, 1, 2, 0, "R10 lookup result installed");
    endtask

    task automatic test_reset_clears();
        test_reset();
        access(16'h4000, 0, 0, 3, 1, "R1 reset cleared valid bits");
    endtask

    initial begin
        test_reset();
        test_fill_and_hits();
        test_eviction();
        test_probe_tag_match();
        test_ext_inv();
        test_inv_during_miss();
        test_reset_clears();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule